// File: doc/BRIEF.md
# Scrambler Auto-Synchronization Controller

This block holds a 23-stage self-synchronizing scrambler together with the sequencer that locks it to an incoming scrambled-ones line signal without outside help. In normal operation the shift register runs as a descrambler or as a scrambler, chosen by a mode input. When the lock procedure is enabled, the sequencer takes over that choice. First it seeds the register from the received bits for a fixed stretch. Then it lets the register run free as a scrambled-ones generator and counts how often the generated bit agrees with the detected bit.

When the agreement count climbs strictly above a programmable threshold, the block raises a sticky sync flag and parks in scrambled-ones mode. If the observation window ends first, the procedure starts again from the seeding stretch with a cleared count. The register advances on a bit strobe. In two-level line mode it advances on every second strobe only, because only sign bits carry information at the symbol rate. The decision slicer sits outside the block; it supplies the detected bit.

Top module: `scr_autosync`

## Requirements
- R1: After reset, scr_out, locked and sync_irq are all 0, and the shift register holds all zeros.
- R2: With lock_en low, every register update computes out = d ^ s[18] ^ s[23], where s[k] is the bit entered k updates ago. If descr_on is 1 the received bit d is shifted in (descrambling). If descr_on is 0 the value out is shifted in (scrambling). scr_out presents out of the latest update from the edge of that update on.
- R3: While the lock procedure runs, descr_on has no effect. The procedure begins with 23 updates in descrambling mode.
- R4: After seeding, the register runs for up to 128 updates in scrambled-ones mode (d forced to 1, out shifted in). Each update whose out equals det_bit adds one to an 8-bit saturating match count.
- R5: The sync test is strict greater-than against sync_thresh and is made on every window update. For a matching line stream, sync_irq and locked rise at the edge of update 23 + sync_thresh + 1, and not one update earlier.
- R6: After sync the register stays in scrambled-ones mode while lock_en is high, so scr_out keeps tracking a scrambled-ones line stream.
- R7: If 128 window updates pass without the test succeeding, the procedure restarts from the 23-update seeding phase with the match count cleared.
- R8: sync_irq is sticky. Only a high irq_clr clears it, and lowering lock_en leaves it set. A set on the same cycle wins over a clear.
- R9: Lowering lock_en clears locked on the next edge and returns the mode choice to descr_on.
- R10: When two_level is 1, the register updates only on every second bit_en strobe counted from reset (the 2nd, 4th, ...). When two_level is 0 it updates on every strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | Bit-rate update strobe |
| det_bit | input | 1 | Detected bit from the external slicer |
| two_level | input | 1 | 1: update at half the strobe rate |
| descr_on | input | 1 | Normal mode: 1 descramble, 0 scramble |
| lock_en | input | 1 | Run the automatic lock procedure |
| sync_thresh | input | 8 | Match count that must be exceeded |
| irq_clr | input | 1 | Clear pulse for sync_irq |
| scr_out | output | 1 | Registered scrambler/descrambler output |
| locked | output | 1 | Procedure finished with sync |
| sync_irq | output | 1 | Sticky sync flag |

## Verification
The bench drives a matching scrambled-ones line stream and probes the exact update on which sync appears. It uses thresholds of 10 and 127, where 127 needs a perfect window. A design that compares with greater-or-equal, or that skips the check on some window updates, flags one update early or late. A threshold of 128 can never be passed, so that window has to expire; the threshold is then lowered. A design that fails to clear the count on restart flags at once, and one that skips reseeding flags 23 updates early. Other runs check that two-level mode advances only on alternate strobes, that the flag survives lowering the enable until cleared, and that after the enable is dropped the register descrambles the same stream back to ones.

// File: rtl/scr_autosync_pkg.sv
`timescale 1ns/1ps
package scr_autosync_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_SEED, ST_WIN, ST_DONE} lock_st_t;
  typedef enum logic [1:0] {MD_DESCR, MD_SCR, MD_ONES} lfsr_md_t;
endpackage

// File: rtl/scr_lfsr.sv
`timescale 1ns/1ps
module scr_lfsr
  import scr_autosync_pkg::*;
#(
  parameter int LEN   = 23,
  parameter int TAP_A = 18,
  parameter int TAP_B = 23
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     upd,
  input  lfsr_md_t mode,
  input  logic     din,
  output logic     fb,
  output logic     out_q
);
  logic [LEN-1:0] sr;
  logic           d_eff;
  logic           shin;

  always_comb begin
    d_eff = (mode == MD_ONES) ? 1'b1 : din;
    fb    = d_eff ^ sr[TAP_A-1] ^ sr[TAP_B-1];
    shin  = (mode == MD_DESCR) ? d_eff : fb;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr    <= '0;
      out_q <= 1'b0;
    end else if (upd) begin
      sr    <= {sr[LEN-2:0], shin};
      out_q <= fb;
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !upd |=> $stable(out_q));
endmodule

// File: rtl/scr_match_cnt.sv
`timescale 1ns/1ps
module scr_match_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt,
  output logic [W-1:0] cnt_nxt
);
  localparam logic [W-1:0] CMAX = '1;

  always_comb cnt_nxt = (inc && cnt != CMAX) ? cnt + 1'b1 : cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) cnt <= '0;
    else            cnt <= cnt_nxt;
  end

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && cnt == CMAX) |=> cnt == CMAX);
endmodule

// File: rtl/scr_lock_fsm.sv
`timescale 1ns/1ps
module scr_lock_fsm
  import scr_autosync_pkg::*;
#(
  parameter int SEED_CYCLES = 23,
  parameter int WIN_CYCLES  = 128,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             lock_en,
  input  logic             upd,
  input  logic             descr_on,
  input  logic [CNT_W-1:0] cnt_nxt,
  input  logic [CNT_W-1:0] thresh,
  output lfsr_md_t         mode,
  output lock_st_t         st,
  output logic             cnt_clr,
  output logic             cnt_inc_en,
  output logic             sync_set,
  output logic             locked_q
);
  localparam int SW = (SEED_CYCLES > 1) ? $clog2(SEED_CYCLES) : 1;
  localparam int WW = (WIN_CYCLES > 1) ? $clog2(WIN_CYCLES) : 1;
  localparam logic [SW-1:0] SEED_LAST = SW'(SEED_CYCLES - 1);
  localparam logic [WW-1:0] WIN_LAST  = WW'(WIN_CYCLES - 1);

  lock_st_t      st_nxt;
  logic [SW-1:0] seed_cnt, seed_nxt;
  logic [WW-1:0] win_cnt, win_nxt;
  logic          exceed;

  always_comb begin
    exceed     = cnt_nxt > thresh;
    st_nxt     = st;
    seed_nxt   = seed_cnt;
    win_nxt    = win_cnt;
    sync_set   = 1'b0;
    cnt_inc_en = (st == ST_WIN) && upd;
    cnt_clr    = (st == ST_SEED);
    if (!lock_en) begin
      st_nxt = ST_IDLE;
    end else begin
      unique case (st)
        ST_IDLE: begin
          st_nxt   = ST_SEED;
          seed_nxt = '0;
        end
        ST_SEED: if (upd) begin
          if (seed_cnt == SEED_LAST) begin
            st_nxt  = ST_WIN;
            win_nxt = '0;
          end else begin
            seed_nxt = seed_cnt + 1'b1;
          end
        end
        ST_WIN: if (upd) begin
          if (exceed) begin
            st_nxt   = ST_DONE;
            sync_set = 1'b1;
          end else if (win_cnt == WIN_LAST) begin
            st_nxt   = ST_SEED;
            seed_nxt = '0;
          end else begin
            win_nxt = win_cnt + 1'b1;
          end
        end
        default: st_nxt = ST_DONE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_IDLE: mode = descr_on ? MD_DESCR : MD_SCR;
      ST_SEED: mode = MD_DESCR;
      default: mode = MD_ONES;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      seed_cnt <= '0;
      win_cnt  <= '0;
      locked_q <= 1'b0;
    end else begin
      st       <= st_nxt;
      seed_cnt <= seed_nxt;
      win_cnt  <= win_nxt;
      locked_q <= (st_nxt == ST_DONE);
    end
  end

  // R3
  seed_mode_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SEED) |-> (mode == MD_DESCR));
endmodule

// File: rtl/scr_autosync.sv
`timescale 1ns/1ps
module scr_autosync
  import scr_autosync_pkg::*;
#(
  parameter int LFSR_LEN    = 23,
  parameter int TAP_A       = 18,
  parameter int TAP_B       = 23,
  parameter int SEED_CYCLES = 23,
  parameter int WIN_CYCLES  = 128,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_en,
  input  logic             det_bit,
  input  logic             two_level,
  input  logic             descr_on,
  input  logic             lock_en,
  input  logic [CNT_W-1:0] sync_thresh,
  input  logic             irq_clr,
  output logic             scr_out,
  output logic             locked,
  output logic             sync_irq
);
  logic             phase;
  logic             upd;
  logic             fb;
  lfsr_md_t         mode;
  lock_st_t         st;
  logic             cnt_clr, cnt_inc_en, sync_set;
  logic [CNT_W-1:0] cnt, cnt_nxt;

  assign upd = bit_en && (!two_level || phase);

  always_ff @(posedge clk) begin
    if (rst)         phase <= 1'b0;
    else if (bit_en) phase <= ~phase;
  end

  scr_lfsr #(.LEN(LFSR_LEN), .TAP_A(TAP_A), .TAP_B(TAP_B)) u_lfsr (
    .clk(clk), .rst(rst), .upd(upd), .mode(mode), .din(det_bit),
    .fb(fb), .out_q(scr_out)
  );

  scr_match_cnt #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr),
    .inc(cnt_inc_en && (fb == det_bit)),
    .cnt(cnt), .cnt_nxt(cnt_nxt)
  );

  scr_lock_fsm #(.SEED_CYCLES(SEED_CYCLES), .WIN_CYCLES(WIN_CYCLES), .CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst(rst), .lock_en(lock_en), .upd(upd), .descr_on(descr_on),
    .cnt_nxt(cnt_nxt), .thresh(sync_thresh), .mode(mode), .st(st),
    .cnt_clr(cnt_clr), .cnt_inc_en(cnt_inc_en), .sync_set(sync_set),
    .locked_q(locked)
  );

  always_ff @(posedge clk) begin
    if (rst)           sync_irq <= 1'b0;
    else if (sync_set) sync_irq <= 1'b1;
    else if (irq_clr)  sync_irq <= 1'b0;
  end

  // R8
  irq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (sync_irq && !irq_clr) |=> sync_irq);
  // R5
  lock_flag_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> sync_irq);
  // R9
  unlock_chk: assert property (@(posedge clk) disable iff (rst)
    !lock_en |=> !locked);
  // R7
  win_start_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WIN && $past(st) == ST_SEED) |-> cnt == '0);
  // R10
  half_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (two_level && upd) |=> !upd);
endmodule

// File: tb/scr_autosync_test.sv
`timescale 1ns/1ps
module scr_autosync_test;
  logic       clk = 1'b0;
  logic       rst, bit_en, det_bit, two_level, descr_on, lock_en, irq_clr;
  logic [7:0] sync_thresh;
  logic       scr_out, locked, sync_irq;
  int         n_chk = 0;
  int         n_fail = 0;
  logic [22:0] tx_s;
  logic        last_tx;

  always #2.5 clk = ~clk;

  scr_autosync uut (
    .clk(clk), .rst(rst), .bit_en(bit_en), .det_bit(det_bit),
    .two_level(two_level), .descr_on(descr_on), .lock_en(lock_en),
    .sync_thresh(sync_thresh), .irq_clr(irq_clr),
    .scr_out(scr_out), .locked(locked), .sync_irq(sync_irq)
  );

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic be, input logic d);
    @(negedge clk);
    bit_en  = be;
    det_bit = d;
    @(posedge clk);
    #1;
  endtask

  task automatic send_ones();
    logic b;
    b       = 1'b1 ^ tx_s[17] ^ tx_s[22];
    tx_s    = {tx_s[21:0], b};
    last_tx = b;
    step(1'b1, b);
  endtask

  task automatic do_reset();
    rst = 1'b1; bit_en = 0; det_bit = 0; two_level = 0; descr_on = 0;
    lock_en = 0; irq_clr = 0; sync_thresh = 8'd0;
    tx_s = 23'h1A2B3C; last_tx = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    check(scr_out == 0, "R1 scr_out", scr_out, 0);
    check(locked == 0, "R1 locked", locked, 0);
    check(sync_irq == 0, "R1 sync_irq", sync_irq, 0);
  endtask

  task automatic t_descr();
    logic [22:0] s = 23'h3F00A5;
    logic d, o;
    int bad = 0;
    do_reset();
    descr_on = 1'b1;
    for (int k = 1; k <= 45; k++) begin
      d = (k % 3 == 0);
      o = d ^ s[17] ^ s[22];
      s = {s[21:0], o};
      step(1'b1, o);
      if (k > 23 && scr_out != d) bad++;
    end
    check(bad == 0, "R2 descramble recovers data", bad, 0);
  endtask

  task automatic t_scr();
    logic [22:0] m = '0;
    logic d, o;
    int bad = 0;
    do_reset();
    descr_on = 1'b0;
    for (int k = 1; k <= 40; k++) begin
      d = (k % 5 == 1) || (k % 7 == 0);
      o = d ^ m[17] ^ m[22];
      m = {m[21:0], o};
      step(1'b1, d);
      if (scr_out != o) bad++;
    end
    check(bad == 0, "R2 scramble output", bad, 0);
  endtask

  task automatic t_sync();
    int bad = 0;
    do_reset();
    descr_on = 1'b0;
    sync_thresh = 8'd10;
    lock_en = 1'b1;
    step(1'b0, 1'b0);
    repeat (23 + 10) send_ones();
    check(sync_irq == 0, "R3 R5 no flag one update early", sync_irq, 0);
    check(locked == 0, "R5 not locked early", locked, 0);
    send_ones();
    check(sync_irq == 1, "R5 flag at update 23+T+1", sync_irq, 1);
    check(locked == 1, "R5 locked at update 23+T+1", locked, 1);
    for (int k = 0; k < 8; k++) begin
      send_ones();
      if (scr_out != last_tx) bad++;
    end
    check(bad == 0, "R6 stays in scrambled-ones mode", bad, 0);
    check(locked == 1, "R6 still locked", locked, 1);
    lock_en = 1'b0;
    descr_on = 1'b1;
    step(1'b0, 1'b0);
    check(locked == 0, "R9 locked clears", locked, 0);
    check(sync_irq == 1, "R8 flag survives lock_en low", sync_irq, 1);
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      send_ones();
      if (scr_out != 1'b1) bad++;
    end
    check(bad == 0, "R9 descr_on governs again", bad, 0);
    step(1'b0, 1'b0);
    check(sync_irq == 1, "R8 flag held without clear", sync_irq, 1);
    irq_clr = 1'b1;
    step(1'b0, 1'b0);
    irq_clr = 1'b0;
    check(sync_irq == 0, "R8 flag cleared by irq_clr", sync_irq, 0);
  endtask

  task automatic t_bound127();
    do_reset();
    sync_thresh = 8'd127;
    lock_en = 1'b1;
    step(1'b0, 1'b0);
    repeat (23 + 127) send_ones();
    check(sync_irq == 0, "R5 T=127 not before last update", sync_irq, 0);
    send_ones();
    check(sync_irq == 1, "R4 R5 T=127 flags on update 128", sync_irq, 1);
  endtask

  task automatic t_restart();
    do_reset();
    sync_thresh = 8'd128;
    lock_en = 1'b1;
    step(1'b0, 1'b0);
    repeat (23 + 128) send_ones();
    check(sync_irq == 0, "R7 T=128 never exceeded", sync_irq, 0);
    check(locked == 0, "R7 window expired unlocked", locked, 0);
    sync_thresh = 8'd10;
    repeat (23 + 10) send_ones();
    check(sync_irq == 0, "R7 reseed and cleared count", sync_irq, 0);
    send_ones();
    check(sync_irq == 1, "R7 sync after restart", sync_irq, 1);
  endtask

  task automatic t_two();
    do_reset();
    two_level = 1'b1;
    sync_thresh = 8'd5;
    lock_en = 1'b1;
    step(1'b0, 1'b0);
    for (int k = 0; k < 28; k++) begin
      step(1'b1, 1'b0);
      send_ones();
    end
    check(sync_irq == 0, "R10 no flag after 56 strobes", sync_irq, 0);
    step(1'b1, 1'b0);
    check(sync_irq == 0, "R10 odd strobe does not update", sync_irq, 0);
    send_ones();
    check(sync_irq == 1, "R10 flag on strobe 58", sync_irq, 1);
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_descr();
    t_scr();
    t_sync();
    t_bound127();
    t_restart();
    t_two();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule